// File: doc/BRIEF.md
# Body-Bias Boot Programming Sequencer

This block is a small bus master that brings a body-bias controller up at boot with no software involvement. It receives one `start` pulse together with the register addresses, a completion-bit mask, the requested operating point and the reference oscillator frequency in hertz. It first decides whether any programming is needed at all. It then derives a settle count from the oscillator frequency through three rounded integer divisions. After that it issues a fixed series of single-beat register writes, polls the status register for completion, and acknowledges the completion.

The three divisions share one sequential restoring divider, so no wide combinational divider is built. Fuse-based qualification is reduced to a single pass/fail input from outside. The result is reported as a one-cycle `done` pulse, and `error` holds until the next request.

Top module: `bbias_seq`

## Requirements
- R1: When the setup, control or status address captured at `start` is zero, the sequence ends with `done` and `error`=0 and makes no bus request.
- R2: `opp_sel` 2'b01 selects the fast point and 2'b10 the slow point. Codes 2'b00 and 2'b11 end the sequence with `done`, `error`=0 and no bus request.
- R3: When both `fuse_addr` and `ldo_addr` are nonzero and `fuse_ok` is 0, the sequence ends quietly: `done`, `error`=0, no bus request. When either of those addresses is zero, `fuse_ok` has no effect.
- R4: The settle count is computed as follows, where each division rounds by adding half the divisor (floored) before dividing. First, r = (osc_hz + 500000) / 1000000. Second, c = (CLK_CYCLES*10 + r/2) / r. Third, n = (SETTLE_US*10 + c/2) / c. The field value is (n shifted left to the lowest set bit of SETUP_CNT_MASK) ANDed with SETUP_CNT_MASK.
- R5: For a programmed run the writes are, in this order:
  1. setup ← 0
  2. control ← 0
  3. setup ← field
  4. status ← mask
  5. setup ← field | bias-type bit | SETUP_EN_MASK
  6. control ← point-select bit | CTRL_TRIG_MASK

  The bias-type bit is SETUP_FBB_MASK for the fast point and SETUP_RBB_MASK for the slow point. The point-select bit is CTRL_FAST_MASK or CTRL_SLOW_MASK.
- R6: After the sixth write the block only reads, always from the status address. It stops polling once every bit of the mask reads as 1.
- R7: If the mask bits are not all set by a read that completes after TIMEOUT poll cycles, `error` rises together with `done`.
- R8: A final write of the mask to the status address follows the poll, whether the poll succeeded or timed out.
- R9: If r or c evaluates to zero, the sequence ends with `done` and `error`=1 and makes no bus request.
- R10: Once `bus_req` is raised, it and `bus_we`, `bus_addr` and `bus_wdata` stay unchanged until the cycle in which `bus_ack` is sampled high.
- R11: After reset, `busy`, `done`, `error` and `bus_req` are 0. `busy` is high from the cycle after an accepted `start` through the single cycle in which `done` is high. `start` is ignored while busy. `error` keeps its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted while idle |
| opp_sel | input | 2 | Operating point: 01 fast, 10 slow |
| setup_addr | input | AW | Setup register address |
| ctrl_addr | input | AW | Control register address |
| stat_addr | input | AW | Status register address |
| fuse_addr | input | AW | Fuse register address (0 = no fuse check) |
| ldo_addr | input | AW | LDO voltage register address (0 = no fuse check) |
| done_mask | input | DW | Completion bits in the status register |
| osc_hz | input | 32 | Reference oscillator frequency in Hz |
| fuse_ok | input | 1 | Result of the external fuse check |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Transfer completes in the cycle it is sampled high |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Timeout or zero divisor in the last run |

## Verification
The embedded assertions check the following on every cycle:
- each divider result is the exact floor quotient of its operands;
- no zero divisor is ever launched;
- bus requests hold steady until acknowledged;
- `done` lasts one cycle;
- no request appears while idle;
- `error` only rises with `done`;
- a full completion read always leads to the clearing write.

Only the bench scenarios can show the remaining behaviour, because each needs a bus model and a whole run. This covers the exact write order and values, the rounded settle count (including a count too large for its field), the three quiet early exits, the zero-divisor exits, the timeout path with its final clear, and the rejection of a second `start`.

// File: rtl/bbias_pkg.sv
// Package: shared types and helpers of the body-bias sequencer.
// Assumes: masks handed to low_bit are nonzero; zero yields bit 0.
package bbias_pkg;

    // Width of the sequential divider operands (covers osc_hz + rounding term).
    localparam int unsigned DIV_W = 34;

    typedef enum logic [1:0] {
        OPP_NONE = 2'b00,
        OPP_FAST = 2'b01,
        OPP_SLOW = 2'b10,
        OPP_RSVD = 2'b11
    } opp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CALC,
        ST_WRITE,
        ST_POLL,
        ST_FIN
    } seq_st_e;

    // Position of the lowest set bit of a mask.
    function automatic int unsigned low_bit(input logic [31:0] m);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/bbias_div.sv
// Module: sequential restoring divider, one quotient bit per clock.
// Assumes: start is only pulsed while idle and den is nonzero; the result
// is valid for one cycle in 'valid', W cycles after start.
module bbias_div #(
    parameter int unsigned W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         valid,
    output logic [W-1:0] quot
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, valid_q;
    logic [W:0]    rem_sh, rem_sub;
    logic          ge;

    // Shift in the next dividend bit and compare against the divisor.
    always_comb begin
        rem_sh  = {rem_q, quo_q[W-1]};
        ge      = rem_sh >= {1'b0, den_q};
        rem_sub = rem_sh - {1'b0, den_q};
    end

    // Iterate one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start && !run_q) begin
                rem_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= ge ? rem_sub[W-1:0] : rem_sh[W-1:0];
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid = valid_q;
    assign quot  = quo_q;

    // Operand copies kept only for the exactness check.
    logic [W-1:0] chk_num_q, chk_den_q;
    // Capture operands of each launched division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_num_q <= '0;
            chk_den_q <= '0;
        end else if (start && !run_q) begin
            chk_num_q <= num;
            chk_den_q <= den;
        end
    end

    // R4: every result is the floor quotient of the launched operands.
    p_div_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (({{W{1'b0}}, quot} * {{W{1'b0}}, chk_den_q}) <= {{W{1'b0}}, chk_num_q}) &&
                  (({{W{1'b0}}, chk_num_q} - ({{W{1'b0}}, quot} * {{W{1'b0}}, chk_den_q})) < {{W{1'b0}}, chk_den_q}));

endmodule

// File: rtl/bbias_calc.sv
// Module: settle-count calculator; runs three rounded divisions on one
// shared divider (MHz rate, cycles per microsecond step, settle count).
// Assumes: start is pulsed only when the previous result was consumed.
module bbias_calc
    import bbias_pkg::*;
#(
    parameter int unsigned CLK_CYCLES = 8,
    parameter int unsigned SETTLE_US  = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      osc_hz,
    output logic             valid,
    output logic             div0,
    output logic [DIV_W-1:0] count
);
    localparam logic [DIV_W-1:0] HZ_PER_MHZ = DIV_W'(1000000);
    localparam logic [DIV_W-1:0] CYC_X10    = DIV_W'(CLK_CYCLES * 10);
    localparam logic [DIV_W-1:0] SET_X10    = DIV_W'(SETTLE_US * 10);

    logic [1:0]       step_q;
    logic             run_q, go_q, valid_q, div0_q;
    logic [DIV_W-1:0] num_q, den_q, cnt_q, quot;
    logic             dv;

    bbias_div #(.W(DIV_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_q),
        .num   (num_q),
        .den   (den_q),
        .valid (dv),
        .quot  (quot)
    );

    // Chain the three divisions, stopping early on a zero divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            run_q   <= 1'b0;
            go_q    <= 1'b0;
            valid_q <= 1'b0;
            div0_q  <= 1'b0;
            num_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
        end else begin
            go_q    <= 1'b0;
            valid_q <= 1'b0;
            if (start && !run_q) begin
                run_q  <= 1'b1;
                step_q <= 2'd0;
                div0_q <= 1'b0;
                num_q  <= DIV_W'(osc_hz) + (HZ_PER_MHZ >> 1);
                den_q  <= HZ_PER_MHZ;
                go_q   <= 1'b1;
            end else if (run_q && dv) begin
                if (step_q == 2'd2) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                    cnt_q   <= quot;
                end else if (quot == '0) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                    div0_q  <= 1'b1;
                end else begin
                    step_q <= step_q + 2'd1;
                    den_q  <= quot;
                    num_q  <= ((step_q == 2'd0) ? CYC_X10 : SET_X10) + (quot >> 1);
                    go_q   <= 1'b1;
                end
            end
        end
    end

    assign valid = valid_q;
    assign div0  = div0_q;
    assign count = cnt_q;

    // R9: the shared divider is never launched with a zero divisor.
    p_den_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> (den_q != '0));

endmodule

// File: rtl/bbias_seq.sv
// Module: body-bias boot programming sequencer (top). Qualifies the
// request, computes the settle count, drives an ordered write series on
// a single-beat req/ack bus, polls completion with a cycle timeout and
// clears it.
// Assumes: the slave acknowledges every request eventually; request
// inputs may change after start (they are captured).
module bbias_seq
    import bbias_pkg::*;
#(
    parameter int unsigned AW              = 16,
    parameter int unsigned DW              = 32,
    parameter int unsigned CLK_CYCLES      = 8,
    parameter int unsigned SETTLE_US       = 50,
    parameter int unsigned TIMEOUT         = 1000,
    parameter logic [DW-1:0] SETUP_EN_MASK  = 32'h0000_0001,
    parameter logic [DW-1:0] SETUP_RBB_MASK = 32'h0000_0002,
    parameter logic [DW-1:0] SETUP_FBB_MASK = 32'h0000_0004,
    parameter logic [DW-1:0] SETUP_CNT_MASK = 32'h0000_FF00,
    parameter logic [DW-1:0] CTRL_TRIG_MASK = 32'h0000_0001,
    parameter logic [DW-1:0] CTRL_FAST_MASK = 32'h0000_0004,
    parameter logic [DW-1:0] CTRL_SLOW_MASK = 32'h0000_0008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    opp_sel,
    input  logic [AW-1:0] setup_addr,
    input  logic [AW-1:0] ctrl_addr,
    input  logic [AW-1:0] stat_addr,
    input  logic [AW-1:0] fuse_addr,
    input  logic [AW-1:0] ldo_addr,
    input  logic [DW-1:0] done_mask,
    input  logic [31:0]   osc_hz,
    input  logic          fuse_ok,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          error
);
    localparam int unsigned CNT_SH = low_bit(SETUP_CNT_MASK);
    localparam int unsigned TW     = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] TMO  = TW'(TIMEOUT);
    localparam logic [2:0] STEP_TRIG  = 3'd5;
    localparam logic [2:0] STEP_CLEAR = 3'd6;

    seq_st_e          st_q;
    logic [2:0]       step_q;
    logic [TW-1:0]    tmo_q;
    logic [1:0]       opp_q;
    logic [AW-1:0]    setup_q, ctrl_q, stat_q, fuse_q, ldo_q;
    logic [DW-1:0]    mask_q, field_q;
    logic [31:0]      osc_q;
    logic             error_q, err_pend_q, fuse_ok_q;
    logic             skip, calc_go, calc_valid, calc_div0;
    logic [DIV_W-1:0] calc_cnt;
    logic [DIV_W+DW-1:0] cnt_wide;
    logic [DW-1:0]    cnt_field, type_bit, sel_bit;

    bbias_calc #(.CLK_CYCLES(CLK_CYCLES), .SETTLE_US(SETTLE_US)) calc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (calc_go),
        .osc_hz (osc_q),
        .valid  (calc_valid),
        .div0   (calc_div0),
        .count  (calc_cnt)
    );

    // Request qualification, settle field placement and per-point bits.
    always_comb begin
        skip = (setup_q == '0) || (ctrl_q == '0) || (stat_q == '0) ||
               !((opp_q == OPP_FAST) || (opp_q == OPP_SLOW)) ||
               ((fuse_q != '0) && (ldo_q != '0) && !fuse_ok_q);
        calc_go   = (st_q == ST_CHECK) && !skip;
        cnt_wide  = {{DW{1'b0}}, calc_cnt} << CNT_SH;
        cnt_field = cnt_wide[DW-1:0] & SETUP_CNT_MASK;
        type_bit  = (opp_q == OPP_FAST) ? SETUP_FBB_MASK : SETUP_RBB_MASK;
        sel_bit   = (opp_q == OPP_FAST) ? CTRL_FAST_MASK : CTRL_SLOW_MASK;
    end

    // Main sequencer: capture, check, compute, write, poll, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            step_q     <= '0;
            tmo_q      <= '0;
            opp_q      <= '0;
            setup_q    <= '0;
            ctrl_q     <= '0;
            stat_q     <= '0;
            fuse_q     <= '0;
            ldo_q      <= '0;
            mask_q     <= '0;
            field_q    <= '0;
            osc_q      <= '0;
            fuse_ok_q  <= 1'b0;
            error_q    <= 1'b0;
            err_pend_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    opp_q      <= opp_sel;
                    setup_q    <= setup_addr;
                    ctrl_q     <= ctrl_addr;
                    stat_q     <= stat_addr;
                    fuse_q     <= fuse_addr;
                    ldo_q      <= ldo_addr;
                    mask_q     <= done_mask;
                    osc_q      <= osc_hz;
                    fuse_ok_q  <= fuse_ok;
                    error_q    <= 1'b0;
                    err_pend_q <= 1'b0;
                    st_q       <= ST_CHECK;
                end
                ST_CHECK: st_q <= skip ? ST_FIN : ST_CALC;
                ST_CALC: if (calc_valid) begin
                    if (calc_div0) begin
                        error_q <= 1'b1;
                        st_q    <= ST_FIN;
                    end else begin
                        field_q <= cnt_field;
                        step_q  <= '0;
                        st_q    <= ST_WRITE;
                    end
                end
                ST_WRITE: if (bus_ack) begin
                    if (step_q == STEP_TRIG) begin
                        tmo_q <= '0;
                        st_q  <= ST_POLL;
                    end else if (step_q == STEP_CLEAR) begin
                        error_q <= err_pend_q;
                        st_q    <= ST_FIN;
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                ST_POLL: begin
                    if (tmo_q < TMO) tmo_q <= tmo_q + 1'b1;
                    if (bus_ack) begin
                        if ((bus_rdata & mask_q) == mask_q) begin
                            step_q <= STEP_CLEAR;
                            st_q   <= ST_WRITE;
                        end else if (tmo_q >= TMO) begin
                            err_pend_q <= 1'b1;
                            step_q     <= STEP_CLEAR;
                            st_q       <= ST_WRITE;
                        end
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Bus transfer contents for the current step.
    always_comb begin
        bus_req   = (st_q == ST_WRITE) || (st_q == ST_POLL);
        bus_we    = (st_q == ST_WRITE);
        bus_addr  = stat_q;
        bus_wdata = '0;
        if (st_q == ST_WRITE) begin
            case (step_q)
                3'd0: bus_addr = setup_q;
                3'd1: bus_addr = ctrl_q;
                3'd2: begin bus_addr = setup_q; bus_wdata = field_q; end
                3'd4: begin bus_addr = setup_q; bus_wdata = field_q | type_bit | SETUP_EN_MASK; end
                3'd5: begin bus_addr = ctrl_q;  bus_wdata = sel_bit | CTRL_TRIG_MASK; end
                default: begin bus_addr = stat_q; bus_wdata = mask_q; end
            endcase
        end
    end

    assign busy  = (st_q != ST_IDLE);
    assign done  = (st_q == ST_FIN);
    assign error = error_q;

    // R10: an unacknowledged request keeps its contents.
    p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    // R11: done is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: no bus activity while idle.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R7: error only rises at the end of a run.
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);

    // R6: a completed read with all mask bits set leads to the clearing write.
    p_poll_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_POLL) && bus_ack && ((bus_rdata & mask_q) == mask_q)) |=>
        ((st_q == ST_WRITE) && (step_q == STEP_CLEAR)));

endmodule

// File: tb/bbias_seq_tb_top.sv
// Bench: directed corners plus seeded random runs against a bus slave
// model with random acknowledge latency and a status completion model.
module bbias_seq_tb_top;
    localparam int unsigned AW  = 16;
    localparam int unsigned DW  = 32;
    localparam int unsigned TMO = 150;
    localparam logic [31:0] S_EN = 32'h1, S_RBB = 32'h2, S_FBB = 32'h4, S_CNT = 32'hFF00;
    localparam logic [31:0] C_TRIG = 32'h1, C_FAST = 32'h4, C_SLOW = 32'h8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fuse_ok = 1'b1;
    logic [1:0] opp_sel = '0;
    logic [AW-1:0] setup_addr = '0, ctrl_addr = '0, stat_addr = '0, fuse_addr = '0, ldo_addr = '0;
    logic [DW-1:0] done_mask = '0, bus_rdata = '0;
    logic [31:0] osc_hz = '0;
    logic bus_req, bus_we, bus_ack = 1'b0, busy, done, error;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    int n_tests = 0, n_fail = 0;
    int n_wr = 0, n_rd = 0, bad_rd = 0, unstable = 0, lat = 0, rdy_cnt = -1, rdy_delay = -1;
    logic [DW-1:0] stat_reg = '0, hw_bits = '0;
    logic [AW-1:0] log_a [16];
    logic [DW-1:0] log_d [16];
    logic [AW-1:0] exp_a [7];
    logic [DW-1:0] exp_d [7];
    bit finished = 0;

    always #4 clk = ~clk;

    bbias_seq #(.AW(AW), .DW(DW), .TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opp_sel(opp_sel),
        .setup_addr(setup_addr), .ctrl_addr(ctrl_addr), .stat_addr(stat_addr),
        .fuse_addr(fuse_addr), .ldo_addr(ldo_addr), .done_mask(done_mask),
        .osc_hz(osc_hz), .fuse_ok(fuse_ok), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .error(error));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Settle count from the R4 formula; -1 when a divisor is zero (R9).
    function automatic longint exp_count(input longint osc);
        longint r, c;
        r = (osc + 500000) / 1000000;
        if (r == 0) return -1;
        c = (80 + r / 2) / r;
        if (c == 0) return -1;
        return (500 + c / 2) / c;
    endfunction

    // Bus slave and status model, evaluated at the falling edge.
    initial begin
        logic [AW-1:0] pa;
        logic [DW-1:0] pd;
        logic pw;
        bit pv;
        pv = 0; pa = '0; pd = '0; pw = 0;
        forever begin
            @(negedge clk);
            if (rdy_cnt > 0) rdy_cnt--;
            else if (rdy_cnt == 0) begin stat_reg = stat_reg | hw_bits; rdy_cnt = -1; end
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (pv && (pa != bus_addr || pd != bus_wdata || pw != bus_we)) unstable++;
                pv = 1; pa = bus_addr; pd = bus_wdata; pw = bus_we;
                if (lat > 0) lat--;
                else begin
                    if (bus_we) begin
                        if (n_wr < 16) begin log_a[n_wr] = bus_addr; log_d[n_wr] = bus_wdata; end
                        n_wr++;
                        if (bus_addr == stat_addr) stat_reg = stat_reg & ~bus_wdata;
                        if (bus_addr == ctrl_addr && (bus_wdata & C_TRIG) != 0 && rdy_delay >= 0)
                            rdy_cnt = rdy_delay;
                    end else begin
                        n_rd++;
                        if (bus_addr != stat_addr) bad_rd++;
                        bus_rdata = (bus_addr == stat_addr) ? stat_reg : '0;
                    end
                    bus_ack = 1'b1;
                    pv = 0;
                    lat = $urandom % 4;
                end
            end
        end
    end

    // One request: kind 0 quiet, 1 zero divisor, 2 programmed.
    task automatic run_case(input string tag, input logic [31:0] osc, input logic [1:0] opp,
                            input logic [AW-1:0] fa, input logic [AW-1:0] la, input bit fok,
                            input logic [AW-1:0] sa, input logic [AW-1:0] ca, input logic [AW-1:0] ta,
                            input logic [DW-1:0] msk, input int rdly, input logic [DW-1:0] hw,
                            input bit inject);
        int cyc, kind, busy_drop;
        longint ec;
        bit exp_err;
        logic err_at_done;
        logic [DW-1:0] fld;
        @(negedge clk);
        osc_hz = osc; opp_sel = opp; fuse_addr = fa; ldo_addr = la; fuse_ok = fok;
        setup_addr = sa; ctrl_addr = ca; stat_addr = ta; done_mask = msk;
        rdy_delay = rdly; hw_bits = hw; stat_reg = '0; rdy_cnt = -1;
        n_wr = 0; n_rd = 0; bad_rd = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; busy_drop = 0;
        while (!done && cyc < 5000) begin
            if (!busy) busy_drop++;
            if (inject && cyc == 20) begin start = 1'b1; opp_sel = 2'b11; osc_hz = 32'd1; end
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, {tag, " run ends with done (R11)"}, done, 1);
        chk(busy == 1'b1 && busy_drop == 0, "R11 busy held through run", busy_drop, 0);
        err_at_done = error;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R11 done one cycle then idle", {done, busy}, 0);
        repeat (3) @(negedge clk);
        chk(error == err_at_done, "R11 error held after run", error, err_at_done);

        ec = exp_count(osc);
        if (sa == 0 || ca == 0 || ta == 0 || !(opp == 2'b01 || opp == 2'b10) ||
            (fa != 0 && la != 0 && !fok)) kind = 0;
        else if (ec < 0) kind = 1;
        else kind = 2;

        if (kind != 2) begin
            chk(n_wr == 0 && n_rd == 0, {tag, " no bus transfers"}, n_wr + n_rd, 0);
            chk(err_at_done == (kind == 1), {tag, " error flag"}, err_at_done, kind == 1);
        end else begin
            fld = 32'((ec << 8) & longint'(S_CNT));
            exp_a[0] = sa; exp_d[0] = '0;
            exp_a[1] = ca; exp_d[1] = '0;
            exp_a[2] = sa; exp_d[2] = fld;
            exp_a[3] = ta; exp_d[3] = msk;
            exp_a[4] = sa; exp_d[4] = fld | ((opp == 2'b01) ? S_FBB : S_RBB) | S_EN;
            exp_a[5] = ca; exp_d[5] = ((opp == 2'b01) ? C_FAST : C_SLOW) | C_TRIG;
            exp_a[6] = ta; exp_d[6] = msk;
            chk(n_wr == 7, {tag, " R5 write count"}, n_wr, 7);
            for (int i = 0; i < 7; i++) begin
                chk(log_a[i] == exp_a[i] && log_d[i] == exp_d[i],
                    (i == 2) ? "R4 settle field write" : ((i == 6) ? "R8 final clear write" : "R5 write order/value"),
                    {log_a[i], log_d[i]}, {exp_a[i], exp_d[i]});
            end
            chk(n_rd >= 1 && bad_rd == 0, "R6 polls read status only", bad_rd, 0);
            exp_err = (rdly < 0) || ((hw & msk) != msk);
            chk(err_at_done == exp_err, {tag, " R7 timeout flag"}, err_at_done, exp_err);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0 && bus_req == 0, "R11 reset state",
            {busy, done, error, bus_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Programmed runs: 20 MHz fast (n=125), 12 MHz slow (n=71), 100 MHz (n=500, field truncated).
        run_case("R5", 32'd20_000_000, 2'b01, 0, 0, 1, 16'h10, 16'h14, 16'h18, 32'h1, 10, 32'h1, 0);
        run_case("R4", 32'd12_000_000, 2'b10, 0, 0, 1, 16'h20, 16'h24, 16'h28, 32'h30, 25, 32'h30, 0);
        run_case("R4", 32'd100_000_000, 2'b01, 0, 0, 1, 16'h20, 16'h24, 16'h28, 32'h2, 5, 32'h2, 0);
        run_case("R4", 32'd38_400_000, 2'b10, 0, 0, 1, 16'h30, 16'h34, 16'h38, 32'h80, 0, 32'h80, 0);
        // Zero addresses.
        run_case("R1", 32'd20_000_000, 2'b01, 0, 0, 1, 16'h0, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        run_case("R1", 32'd20_000_000, 2'b01, 0, 0, 1, 16'h10, 16'h0, 16'h18, 32'h1, 5, 32'h1, 0);
        run_case("R1", 32'd20_000_000, 2'b10, 0, 0, 1, 16'h10, 16'h14, 16'h0, 32'h1, 5, 32'h1, 0);
        // Unsupported operating points.
        run_case("R2", 32'd20_000_000, 2'b00, 0, 0, 1, 16'h10, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        run_case("R2", 32'd20_000_000, 2'b11, 0, 0, 1, 16'h10, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        // Fuse check fails, and fuse_ok ignored when one address is zero.
        run_case("R3", 32'd20_000_000, 2'b01, 16'h40, 16'h44, 0, 16'h10, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        run_case("R3", 32'd20_000_000, 2'b01, 16'h40, 16'h0, 0, 16'h10, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        run_case("R3", 32'd20_000_000, 2'b10, 16'h40, 16'h44, 1, 16'h10, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        // Zero divisors: rate rounds to 0 (400 kHz), cycles round to 0 (200 MHz).
        run_case("R9", 32'd400_000, 2'b01, 0, 0, 1, 16'h10, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        run_case("R9", 32'd200_000_000, 2'b10, 0, 0, 1, 16'h10, 16'h14, 16'h18, 32'h1, 5, 32'h1, 0);
        // Timeouts: never complete, and only part of the mask completes.
        run_case("R7", 32'd20_000_000, 2'b01, 0, 0, 1, 16'h10, 16'h14, 16'h18, 32'h1, -1, 32'h0, 0);
        run_case("R6", 32'd20_000_000, 2'b10, 0, 0, 1, 16'h10, 16'h14, 16'h18, 32'h3, 8, 32'h1, 0);
        // Second start while busy must not disturb the run.
        run_case("R11", 32'd24_000_000, 2'b01, 0, 0, 1, 16'h50, 16'h54, 16'h58, 32'h4, 30, 32'h4, 1);

        for (int k = 0; k < 16; k++) begin
            logic [31:0] o;
            logic [DW-1:0] m;
            o = 32'd1_000_000 + ($urandom % 32'd89_000_000);
            m = 32'h1 << ($urandom % 8);
            if ($urandom % 2) m = m | 32'h100;
            run_case("R5", o, ($urandom % 2) ? 2'b01 : 2'b10,
                     ($urandom % 2) ? 16'h60 : 16'h0, 16'h64, 1,
                     16'h70, 16'h74, 16'h78, m, 1 + int'($urandom % 60), m, 0);
        end

        chk(unstable == 0, "R10 request held until ack", unstable, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule